// File: doc/BRIEF.md
# Reset Source Detector

This block watches the internal conditions that can force a chip reset and turns them into three results: a one-cycle chip reset request, a request to pull the external reset pin low, and a sticky status register that records which source caused the latest reset. Two sources are detected here. The first is an instruction fetch from an address that the address decoder reports as unmapped. The second is a trip of the low-voltage detector. The low-voltage source is honoured only when two configuration bits both allow it.

A power-on reset input initialises the block. It marks power-on as the cause of reset and requests that the reset pin be driven low. Software reads the status register, and the read clears it. The pin-drive request stays up until a separate release counter reports that the reset window is over. This block does not time the reset release, sense voltage, or hold the address map.

Top module: `reset_source_detect`

## Requirements
- R1: When `opcodeFetch` and `addrUnmapped` are both high at a rising edge, `chipRstReq` is high after that edge and status bit 1 (illegal fetch) is set.
- R2: When `addrUnmapped` is high and `opcodeFetch` is low at an edge with no low-voltage event, `chipRstReq` is low after that edge and status bit 1 is not set by it.
- R3: `chipRstReq` is high for exactly the cycle after each edge that sees an event, and is low otherwise.
- R4: A high `lvdTrip` sets status bit 2 (low voltage) and raises `chipRstReq` after the edge only when `cfgLvdPowerDown` and `cfgLvdResetOff` are both 0. Otherwise it has no effect on any output.
- R5: `pinDriveLow` is high in every cycle in which `chipRstReq` is high.
- R6: Once `pinDriveLow` is high, it stays high until an edge at which `releaseDone` is high and no new event occurs. A new event wins over `releaseDone` at the same edge.
- R7: An edge with `statusRd` high clears every status bit. If an event occurs at the same edge, that event's bit is set instead of cleared.
- R8: While `porIn` is high, and until the first event or read afterwards, the outputs are: `statusOut` = 0x01 (bit 0 is power-on), `chipRstReq` = 0, and `pinDriveLow` = 1.
- R9: Status bits stay set across cycles until a read or a power-on reset. Bits 3 and above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| addrUnmapped | input | 1 | Current bus address is not in the memory map |
| opcodeFetch | input | 1 | Current bus cycle fetches an instruction |
| lvdTrip | input | 1 | Low-voltage detector output |
| cfgLvdPowerDown | input | 1 | 1 = low-voltage detector powered down |
| cfgLvdResetOff | input | 1 | 1 = low-voltage reset disabled |
| statusRd | input | 1 | Status register read strobe (clears on read) |
| releaseDone | input | 1 | Release counter finished; drop the pin request |
| statusOut | output | STAT_W | Reset status: bit0 power-on, bit1 illegal fetch, bit2 low voltage |
| chipRstReq | output | 1 | One-cycle chip reset request |
| pinDriveLow | output | 1 | Request to drive the external reset pin low |

## Verification
Every result is registered once. An input pattern applied before a rising edge therefore shows on `chipRstReq`, `pinDriveLow` and `statusOut` right after that edge, and on no later edge. The bench drives inputs on the falling edge. It advances its reference model at the rising edge and compares all three outputs at the next falling edge, which is one full cycle after the stimulus and before the next one is applied. Power-on values are compared while `porIn` is still high, because that reset is asynchronous and takes effect without a clock edge.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int BIT_POR     = 0;
  localparam int BIT_ILLEGAL = 1;
  localparam int BIT_LOWVOLT = 2;
  localparam int NUM_SRC     = 3;

  typedef struct packed {
    logic setIllegal;
    logic setLowVolt;
    logic clrStatus;
  } rsdStrobe_t;
endpackage

// File: rtl/rsd_ctrl.sv
module rsd_ctrl
  import rsd_pkg::*;
(
  input  logic       clk,
  input  logic       porIn,
  input  logic       addrUnmapped,
  input  logic       opcodeFetch,
  input  logic       lvdTrip,
  input  logic       cfgLvdPowerDown,
  input  logic       cfgLvdResetOff,
  input  logic       statusRd,
  output rsdStrobe_t strobe,
  output logic       chipRstReq
);
  logic illegalEv;
  logic lowVoltEv;
  logic lvdAllowed;

  // Qualify the unmapped flag with the fetch type: data reads never reset.
  assign illegalEv  = opcodeFetch & addrUnmapped;
  assign lvdAllowed = ~cfgLvdPowerDown & ~cfgLvdResetOff;
  assign lowVoltEv  = lvdTrip & lvdAllowed;

  always_comb begin
    strobe.setIllegal = illegalEv;
    strobe.setLowVolt = lowVoltEv;
    strobe.clrStatus  = statusRd;
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) chipRstReq <= 1'b0;
    else       chipRstReq <= illegalEv | lowVoltEv;
  end

  AST_DATA_FETCH_QUIET: assert property (@(posedge clk) disable iff (porIn)
    (addrUnmapped && !opcodeFetch && !(lvdTrip && !cfgLvdPowerDown && !cfgLvdResetOff))
      |=> !chipRstReq); // R2
  AST_LVD_GATED: assert property (@(posedge clk) disable iff (porIn)
    (!(opcodeFetch && addrUnmapped) && (cfgLvdPowerDown || cfgLvdResetOff))
      |=> !chipRstReq); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (porIn)
    (!(opcodeFetch && addrUnmapped) && !lvdTrip) |=> !chipRstReq); // R3
endmodule

// File: rtl/rsd_dpath.sv
module rsd_dpath
  import rsd_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              porIn,
  input  rsdStrobe_t        strobe,
  input  logic              releaseDone,
  output logic [STAT_W-1:0] statusOut,
  output logic              pinDriveLow
);
  localparam int SPARE_W = STAT_W - NUM_SRC;

  logic anySet;
  assign anySet = strobe.setIllegal | strobe.setLowVolt;

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == BIT_POR) begin : g_por
      always_ff @(posedge clk or posedge porIn) begin
        if (porIn)                 statusOut[i] <= 1'b1;
        else if (strobe.clrStatus) statusOut[i] <= 1'b0;
      end
    end else if (i == BIT_ILLEGAL || i == BIT_LOWVOLT) begin : g_src
      logic setHere;
      assign setHere = (i == BIT_ILLEGAL) ? strobe.setIllegal : strobe.setLowVolt;
      always_ff @(posedge clk or posedge porIn) begin
        if (porIn)                 statusOut[i] <= 1'b0;
        else if (setHere)          statusOut[i] <= 1'b1;
        else if (strobe.clrStatus) statusOut[i] <= 1'b0;
      end
    end else begin : g_spare
      assign statusOut[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)            pinDriveLow <= 1'b1;
    else if (anySet)      pinDriveLow <= 1'b1;
    else if (releaseDone) pinDriveLow <= 1'b0;
  end

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (porIn)
    (pinDriveLow && !releaseDone) |=> pinDriveLow); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (porIn)
    (strobe.clrStatus && !anySet) |=> (statusOut == '0)); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (porIn)
    (!strobe.clrStatus) |=> ((statusOut & $past(statusOut)) == $past(statusOut))); // R9
  if (SPARE_W > 0) begin : g_spare_chk
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (porIn)
      statusOut[STAT_W-1:NUM_SRC] == '0); // R9
  end
endmodule

// File: rtl/reset_source_detect.sv
module reset_source_detect
  import rsd_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              addrUnmapped,
  input  logic              opcodeFetch,
  input  logic              lvdTrip,
  input  logic              cfgLvdPowerDown,
  input  logic              cfgLvdResetOff,
  input  logic              statusRd,
  input  logic              releaseDone,
  output logic [STAT_W-1:0] statusOut,
  output logic              chipRstReq,
  output logic              pinDriveLow
);
  rsdStrobe_t strobe;

  rsd_ctrl u_ctrl (
    .clk(clk), .porIn(porIn), .addrUnmapped(addrUnmapped),
    .opcodeFetch(opcodeFetch), .lvdTrip(lvdTrip),
    .cfgLvdPowerDown(cfgLvdPowerDown), .cfgLvdResetOff(cfgLvdResetOff),
    .statusRd(statusRd), .strobe(strobe), .chipRstReq(chipRstReq)
  );

  rsd_dpath #(.STAT_W(STAT_W)) u_dpath (
    .clk(clk), .porIn(porIn), .strobe(strobe), .releaseDone(releaseDone),
    .statusOut(statusOut), .pinDriveLow(pinDriveLow)
  );

  AST_ILLEGAL_FETCH: assert property (@(posedge clk) disable iff (porIn)
    (opcodeFetch && addrUnmapped) |=> (chipRstReq && statusOut[BIT_ILLEGAL])); // R1
  AST_PIN_WITH_REQ: assert property (@(posedge clk) disable iff (porIn)
    chipRstReq |-> pinDriveLow); // R5
  AST_LVD_ALLOWED: assert property (@(posedge clk) disable iff (porIn)
    (lvdTrip && !cfgLvdPowerDown && !cfgLvdResetOff)
      |=> (chipRstReq && statusOut[BIT_LOWVOLT])); // R4
endmodule

// File: tb/reset_source_detect_bench.sv
module reset_source_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAT_W = 8;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  logic porIn = 1'b1;
  logic addrUnmapped = 1'b0, opcodeFetch = 1'b0, lvdTrip = 1'b0;
  logic cfgLvdPowerDown = 1'b0, cfgLvdResetOff = 1'b0;
  logic statusRd = 1'b0, releaseDone = 1'b0;
  logic [STAT_W-1:0] statusOut;
  logic chipRstReq, pinDriveLow;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [STAT_W-1:0] expStat;
  logic expChip, expPin;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_source_detect #(.STAT_W(STAT_W)) u_reset_source_detect (
    .clk(clk), .porIn(porIn), .addrUnmapped(addrUnmapped),
    .opcodeFetch(opcodeFetch), .lvdTrip(lvdTrip),
    .cfgLvdPowerDown(cfgLvdPowerDown), .cfgLvdResetOff(cfgLvdResetOff),
    .statusRd(statusRd), .releaseDone(releaseDone),
    .statusOut(statusOut), .chipRstReq(chipRstReq), .pinDriveLow(pinDriveLow)
  );

  function automatic logic evIllegal(logic unm, logic opf);
    return unm & opf;
  endfunction

  function automatic logic evLow(logic lvd, logic pd, logic roff);
    return lvd & ~pd & ~roff;
  endfunction

  function automatic logic [STAT_W-1:0] nextStat(logic [STAT_W-1:0] cur, logic rd,
                                                 logic il, logic lv);
    logic [STAT_W-1:0] n;
    n = rd ? '0 : cur;
    if (il) n[1] = 1'b1;
    if (lv) n[2] = 1'b1;
    return n;
  endfunction

  function automatic logic nextPin(logic cur, logic ev, logic rel);
    return ev ? 1'b1 : (rel ? 1'b0 : cur);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " R1 R2 R3 R4 chipRstReq"}, 32'(chipRstReq), 32'(expChip));
    check({tag, " R5 R6 pinDriveLow"}, 32'(pinDriveLow), 32'(expPin));
    check({tag, " R7 R9 statusOut"}, 32'(statusOut), 32'(expStat));
  endtask

  // Drive at negedge, model at posedge, compare at next negedge.
  task automatic step(logic unm, logic opf, logic lvd, logic pd, logic roff,
                      logic rd, logic rel, string tag);
    logic il, lv;
    addrUnmapped = unm; opcodeFetch = opf; lvdTrip = lvd;
    cfgLvdPowerDown = pd; cfgLvdResetOff = roff; statusRd = rd; releaseDone = rel;
    il = evIllegal(unm, opf);
    lv = evLow(lvd, pd, roff);
    @(posedge clk);
    expChip = il | lv;
    expStat = nextStat(expStat, rd, il, lv);
    expPin  = nextPin(expPin, il | lv, rel);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic doPor();
    @(negedge clk);
    porIn = 1'b1;
    #1;
    expStat = STAT_W'(1); expChip = 1'b0; expPin = 1'b1;
    checkAll("R8 por-asserted");
    @(negedge clk);
    porIn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    expStat = STAT_W'(1); expChip = 1'b0; expPin = 1'b1;
    repeat (2) @(negedge clk);
    checkAll("R8 reset-state");
    porIn = 1'b0;
    // R8: idle cycles keep power-on state
    step(0, 0, 0, 0, 0, 0, 0, "R8 idle");
    // R2: data fetch from unmapped address
    step(1, 0, 0, 0, 0, 0, 0, "R2 data-fetch");
    // R1: opcode fetch from unmapped address
    step(1, 1, 0, 0, 0, 0, 0, "R1 illegal-fetch");
    // R3: pulse drops next cycle; R6 pin held
    step(0, 1, 0, 0, 0, 0, 0, "R3 pulse-end");
    // R6: release drops pin
    step(0, 0, 0, 0, 0, 0, 1, "R6 release");
    // R7: read clears
    step(0, 0, 0, 0, 0, 1, 0, "R7 read-clear");
    // R4: gated by each config bit
    step(0, 0, 1, 1, 0, 0, 0, "R4 lvd-powerdown");
    step(0, 0, 1, 0, 1, 0, 0, "R4 lvd-reset-off");
    step(0, 0, 1, 1, 1, 0, 0, "R4 lvd-both");
    step(0, 0, 1, 0, 0, 0, 0, "R4 lvd-allowed");
    // R6: event beats release at the same edge
    step(1, 1, 0, 0, 0, 0, 1, "R6 set-beats-release");
    // R7: read with simultaneous event keeps that bit
    step(0, 0, 1, 0, 0, 1, 1, "R7 read-with-event");
    step(0, 0, 0, 0, 0, 0, 1, "R9 sticky");
    // R8: power-on mid-run
    doPor();
    step(0, 0, 0, 0, 0, 0, 0, "R8 after-por");
    for (int i = 0; i < N_RAND; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0], r[1], (r[2] & r[3]), r[4], (r[5] & r[6]),
           ($urandom % 8 == 0), ($urandom % 4 == 0), "rand");
      if (i == N_RAND / 2) doPor();
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule